// File: doc/BRIEF.md
# Point-to-Point Memory Race Recorder

This block sits beside one core of a multi-core chip and records the order of memory accesses that cross between cores, one access at a time. It counts the instructions the core retires. For each cache line it tracks, it keeps the instruction position of the last local load or store to that line. When another core sends a coherence request for a line, the block answers with that line's stored position and this core's identifier.

When this core receives such an answer from another core, the block decides whether the answer reveals a new ordering constraint. It keeps one entry per source core holding the highest position already received from that core. Only an answer with a strictly higher position produces a log record. The record names the source core, gives the source's line position, and gives this core's current instruction count. Records leave through a valid/ready stream. While a record waits for acceptance, the block holds off retirement and refuses new answers, so no record is lost.

The filter is a two-state machine. ST_IDLE waits for an answer. Transition T_ACCEPT moves it to ST_EMIT when an accepted answer carries a position above the stored entry. ST_EMIT presents the record, and transition T_DRAIN returns it to ST_IDLE on the cycle the log sink takes the record. An answer that carries no new information keeps the machine in ST_IDLE.

Top module: `race_recorder`

## Requirements
- R1: After reset the instruction count is 0. It rises by exactly one on each clock edge where `retire_i` is 1 and `retire_stall_o` is 0.
- R2: A local access (`acc_valid_i`) stores into line `acc_line_i` the count value of that cycle plus one. This value is the 1-based position of the accessing instruction. A retirement in the same cycle does not change the stored value.
- R3: A remote request in cycle N produces `rrep_valid_o` = 1 in cycle N+1, with `rrep_cnt_o` set to the line's stored position and `rrep_core_o` set to `SELF_ID`. A line never accessed since reset answers 0.
- R4: An accepted answer whose position is strictly greater than the stored entry for its source produces a record in the next cycle. The record has `log_src_o` = the source core, `log_src_cnt_o` = the received position, and `log_dst_cnt_o` = the instruction count in the cycle of reception. The entry for that source becomes the received position.
- R5: An answer whose position is less than or equal to the stored entry for its source emits no record and leaves that entry unchanged.
- R6: An answer with position 0 never emits a record.
- R7: While `log_valid_o` = 1 and `log_ready_i` = 0, the record fields hold steady and `retire_stall_o` = 1. Retirements presented during the stall are not counted.
- R8: `rsp_ready_o` is 0 while a record is pending. An answer presented while it is 0 is ignored and does not update any entry.
- R9: Reset clears the instruction count, every line position and every per-source entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_i | input | 1 | One instruction retires this cycle |
| retire_stall_o | output | 1 | Retirement held off; record pending |
| acc_valid_i | input | 1 | Local load or store this cycle |
| acc_line_i | input | LINE_W | Line index of the local access |
| rreq_valid_i | input | 1 | Remote coherence request for a line |
| rreq_line_i | input | LINE_W | Line index of the remote request |
| rrep_valid_o | output | 1 | Answer to the remote request |
| rrep_cnt_o | output | CNT_W | Stored position of the requested line |
| rrep_core_o | output | CORE_W | This core's identifier |
| rsp_valid_i | input | 1 | Answer from another core arrives |
| rsp_ready_o | output | 1 | Answer can be taken this cycle |
| rsp_core_i | input | CORE_W | Answering core's identifier |
| rsp_cnt_i | input | CNT_W | Answering core's line position |
| log_valid_o | output | 1 | Record available |
| log_ready_i | input | 1 | Log sink takes the record |
| log_src_o | output | CORE_W | Record: source core |
| log_src_cnt_o | output | CNT_W | Record: source line position |
| log_dst_cnt_o | output | CNT_W | Record: local instruction count |

## Verification
The bench sends a series of answers that repeat, lower or equal earlier positions from the same source. A filter that tests with greater-or-equal would log duplicates. A filter that overwrites entries with lower values would later log positions that should be suppressed. It also checks that an access and a retirement in the same cycle store the pre-increment count plus one; an off-by-one there would shift every answer. During a stall it pulses retirement and offers a large answer. A design that kept counting, or that took the answer while busy, shows a wrong local count or a missing later record. A second reset followed by a position-1 answer shows whether the entries and the count were truly cleared.

// File: rtl/rr_pkg.sv
package rr_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } rr_state_e;
endpackage

// File: rtl/rr_instr_counter.sv
module rr_instr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_o <= '0;
        else if (inc_i) cnt_o <= cnt_o + 1'b1;
    end
endmodule

// File: rtl/rr_line_table.sv
module rr_line_table #(
    parameter int CNT_W   = 16,
    parameter int LINE_W  = 3,
    parameter int CORE_W  = 2,
    parameter int SELF_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid_i,
    input  logic [LINE_W-1:0] acc_line_i,
    input  logic [CNT_W-1:0]  acc_pos_i,
    input  logic              rreq_valid_i,
    input  logic [LINE_W-1:0] rreq_line_i,
    output logic              rrep_valid_o,
    output logic [CNT_W-1:0]  rrep_cnt_o,
    output logic [CORE_W-1:0] rrep_core_o
);
    localparam int NLINES = 1 << LINE_W;

    logic [CNT_W-1:0] pos_q [NLINES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NLINES; i++) pos_q[i] <= '0;
        end else if (acc_valid_i) begin
            pos_q[acc_line_i] <= acc_pos_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rrep_valid_o <= 1'b0;
            rrep_cnt_o   <= '0;
        end else begin
            rrep_valid_o <= rreq_valid_i;
            rrep_cnt_o   <= rreq_valid_i ? pos_q[rreq_line_i] : '0;
        end
    end

    assign rrep_core_o = CORE_W'(SELF_ID);

    // R3: a request is always answered on the following cycle
    assert_reply_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rreq_valid_i |=> rrep_valid_o);
endmodule

// File: rtl/rr_dep_filter.sv
module rr_dep_filter
    import rr_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int NUM_CORES = 4,
    parameter int CORE_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rsp_valid_i,
    output logic              rsp_ready_o,
    input  logic [CORE_W-1:0] rsp_core_i,
    input  logic [CNT_W-1:0]  rsp_cnt_i,
    input  logic [CNT_W-1:0]  local_cnt_i,
    output logic              busy_o,
    output logic              log_valid_o,
    input  logic              log_ready_i,
    output logic [CORE_W-1:0] log_src_o,
    output logic [CNT_W-1:0]  log_src_cnt_o,
    output logic [CNT_W-1:0]  log_dst_cnt_o
);
    rr_state_e        state_q, state_d;
    logic [CNT_W-1:0] seen_q [NUM_CORES];
    logic             take, is_new;

    assign take   = rsp_valid_i && (state_q == ST_IDLE);
    assign is_new = rsp_cnt_i > seen_q[rsp_core_i];

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (take && is_new) state_d = ST_EMIT;  // T_ACCEPT
            ST_EMIT: if (log_ready_i)    state_d = ST_IDLE;  // T_DRAIN
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // per-source high-water entries and the pending record
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CORES; i++) seen_q[i] <= '0;
            log_src_o     <= '0;
            log_src_cnt_o <= '0;
            log_dst_cnt_o <= '0;
        end else if (take && is_new) begin
            seen_q[rsp_core_i] <= rsp_cnt_i;
            log_src_o          <= rsp_core_i;
            log_src_cnt_o      <= rsp_cnt_i;
            log_dst_cnt_o      <= local_cnt_i;
        end
    end

    // outputs
    always_comb begin
        rsp_ready_o = 1'b0;
        log_valid_o = 1'b0;
        busy_o      = 1'b0;
        unique case (state_q)
            ST_IDLE: rsp_ready_o = 1'b1;
            ST_EMIT: begin
                log_valid_o = 1'b1;
                busy_o      = 1'b1;
            end
        endcase
    end

    // R7: a stalled record does not change
    assert_record_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (log_valid_o && !log_ready_i) |=> (log_valid_o && $stable(log_src_o)
            && $stable(log_src_cnt_o) && $stable(log_dst_cnt_o)));
    // R6: a zero position never leads to a record
    assert_zero_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_i && rsp_ready_o && rsp_cnt_i == '0) |=> !log_valid_o);
    // R4: a new record only appears after an accepted answer
    assert_record_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(log_valid_o) |-> $past(rsp_valid_i && rsp_ready_o));
endmodule

// File: rtl/race_recorder.sv
module race_recorder #(
    parameter int CNT_W     = 16,
    parameter int LINE_W    = 3,
    parameter int NUM_CORES = 4,
    parameter int SELF_ID   = 0,
    parameter int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              retire_i,
    output logic              retire_stall_o,
    input  logic              acc_valid_i,
    input  logic [LINE_W-1:0] acc_line_i,
    input  logic              rreq_valid_i,
    input  logic [LINE_W-1:0] rreq_line_i,
    output logic              rrep_valid_o,
    output logic [CNT_W-1:0]  rrep_cnt_o,
    output logic [CORE_W-1:0] rrep_core_o,
    input  logic              rsp_valid_i,
    output logic              rsp_ready_o,
    input  logic [CORE_W-1:0] rsp_core_i,
    input  logic [CNT_W-1:0]  rsp_cnt_i,
    output logic              log_valid_o,
    input  logic              log_ready_i,
    output logic [CORE_W-1:0] log_src_o,
    output logic [CNT_W-1:0]  log_src_cnt_o,
    output logic [CNT_W-1:0]  log_dst_cnt_o
);
    logic [CNT_W-1:0] icount;
    logic             busy;

    assign retire_stall_o = busy;

    rr_instr_counter #(.CNT_W(CNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (retire_i && !busy),
        .cnt_o (icount)
    );

    rr_line_table #(
        .CNT_W(CNT_W), .LINE_W(LINE_W), .CORE_W(CORE_W), .SELF_ID(SELF_ID)
    ) u_lines (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc_valid_i  (acc_valid_i),
        .acc_line_i   (acc_line_i),
        .acc_pos_i    (icount + 1'b1),
        .rreq_valid_i (rreq_valid_i),
        .rreq_line_i  (rreq_line_i),
        .rrep_valid_o (rrep_valid_o),
        .rrep_cnt_o   (rrep_cnt_o),
        .rrep_core_o  (rrep_core_o)
    );

    rr_dep_filter #(
        .CNT_W(CNT_W), .NUM_CORES(NUM_CORES), .CORE_W(CORE_W)
    ) u_filter (
        .clk           (clk),
        .rst_n         (rst_n),
        .rsp_valid_i   (rsp_valid_i),
        .rsp_ready_o   (rsp_ready_o),
        .rsp_core_i    (rsp_core_i),
        .rsp_cnt_i     (rsp_cnt_i),
        .local_cnt_i   (icount),
        .busy_o        (busy),
        .log_valid_o   (log_valid_o),
        .log_ready_i   (log_ready_i),
        .log_src_o     (log_src_o),
        .log_src_cnt_o (log_src_cnt_o),
        .log_dst_cnt_o (log_dst_cnt_o)
    );

    // R1: an unstalled retirement advances the count by one
    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_i && !retire_stall_o) |=> icount == $past(icount) + 1'b1);
    // R7: a retirement offered during a stall is not counted
    assert_stall_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        retire_stall_o |=> $stable(icount));
endmodule

// File: tb/test_race_recorder.sv
module test_race_recorder;
    localparam int CNT_W = 16, LINE_W = 3, CORE_W = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic retire_i = 0, acc_valid_i = 0, rreq_valid_i = 0, rsp_valid_i = 0, log_ready_i = 1;
    logic [LINE_W-1:0] acc_line_i = '0, rreq_line_i = '0;
    logic [CORE_W-1:0] rsp_core_i = '0;
    logic [CNT_W-1:0]  rsp_cnt_i = '0;
    logic retire_stall_o, rrep_valid_o, rsp_ready_o, log_valid_o;
    logic [CNT_W-1:0]  rrep_cnt_o, log_src_cnt_o, log_dst_cnt_o;
    logic [CORE_W-1:0] rrep_core_o, log_src_o;

    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    race_recorder i_race_recorder (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic remote_req(input logic [LINE_W-1:0] line, input logic [CNT_W-1:0] exp, input string tag);
        rreq_valid_i = 1; rreq_line_i = line;
        @(negedge clk);
        rreq_valid_i = 0;
        check({tag, " rrep_valid"}, rrep_valid_o, 1);
        check({tag, " rrep_cnt"}, rrep_cnt_o, exp);
        check({tag, " rrep_core"}, rrep_core_o, 0);
    endtask

    // {source[18:17], position[16:1], expect_record[0]}; local count is 13 throughout
    localparam bit [18:0] VEC [8] = '{
        {2'd1, 16'd5, 1'b1},
        {2'd1, 16'd3, 1'b0},
        {2'd1, 16'd5, 1'b0},
        {2'd2, 16'd0, 1'b0},
        {2'd2, 16'd7, 1'b1},
        {2'd1, 16'd6, 1'b1},
        {2'd3, 16'd9, 1'b1},
        {2'd2, 16'd7, 1'b0}
    };

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R9 reset state
        check("R9 log_valid", log_valid_o, 0);
        check("R9 stall", retire_stall_o, 0);
        check("R8 rsp_ready idle", rsp_ready_o, 1);
        remote_req(3, 0, "R3 untouched line");

        // R1: ten retirements
        retire_i = 1;
        repeat (10) @(negedge clk);
        retire_i = 0;
        // R2: access at count 10 stores 11
        acc_valid_i = 1; acc_line_i = 3;
        @(negedge clk);
        // two more retirements, then retire and access together at count 12
        acc_valid_i = 0; retire_i = 1;
        repeat (2) @(negedge clk);
        acc_valid_i = 1; acc_line_i = 5;
        @(negedge clk);
        acc_valid_i = 0; retire_i = 0;
        remote_req(3, 11, "R2 line3");
        remote_req(5, 13, "R2 retire same cycle");

        // table walk: R4 R5 R6 with count 13
        for (int i = 0; i < 8; i++) begin
            rsp_valid_i = 1; rsp_core_i = VEC[i][18:17]; rsp_cnt_i = VEC[i][16:1];
            @(negedge clk);
            rsp_valid_i = 0;
            check($sformatf("R4/R5/R6 vec%0d log_valid", i), log_valid_o, VEC[i][0]);
            if (VEC[i][0]) begin
                check($sformatf("R4 vec%0d src", i), log_src_o, VEC[i][18:17]);
                check($sformatf("R4 vec%0d src_cnt", i), log_src_cnt_o, VEC[i][16:1]);
                check($sformatf("R4 vec%0d dst_cnt (R1)", i), log_dst_cnt_o, 13);
            end
            @(negedge clk);
        end

        // R7 / R8: stalled sink
        log_ready_i = 0;
        rsp_valid_i = 1; rsp_core_i = 3; rsp_cnt_i = 20;
        @(negedge clk);
        rsp_valid_i = 0;
        check("R7 log_valid", log_valid_o, 1);
        check("R7 stall", retire_stall_o, 1);
        check("R8 rsp_ready busy", rsp_ready_o, 0);
        retire_i = 1;
        rsp_valid_i = 1; rsp_core_i = 1; rsp_cnt_i = 100;
        repeat (3) @(negedge clk);
        retire_i = 0; rsp_valid_i = 0;
        check("R7 held valid", log_valid_o, 1);
        check("R7 held src_cnt", log_src_cnt_o, 20);
        check("R7 held dst_cnt", log_dst_cnt_o, 13);
        log_ready_i = 1;
        @(negedge clk);
        check("R7 drained", log_valid_o, 0);
        // R8: the ignored 100 must not have raised source 1's entry
        rsp_valid_i = 1; rsp_core_i = 1; rsp_cnt_i = 50;
        @(negedge clk);
        rsp_valid_i = 0;
        check("R8 ignored answer log_valid", log_valid_o, 1);
        check("R7 stalled retires not counted", log_dst_cnt_o, 13);
        @(negedge clk);
        retire_i = 1;
        @(negedge clk);
        retire_i = 0;
        rsp_valid_i = 1; rsp_core_i = 2; rsp_cnt_i = 8;
        @(negedge clk);
        rsp_valid_i = 0;
        check("R1 count resumes", log_dst_cnt_o, 14);
        check("R4 src2 log_valid", log_valid_o, 1);
        @(negedge clk);

        // R9: second reset clears everything
        do_reset();
        remote_req(3, 0, "R9 line cleared");
        rsp_valid_i = 1; rsp_core_i = 1; rsp_cnt_i = 1;
        @(negedge clk);
        rsp_valid_i = 0;
        check("R9 entry cleared", log_valid_o, 1);
        check("R9 count cleared", log_dst_cnt_o, 0);
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule